// File: doc/BRIEF.md
# IPv6 Address Match Cache with Frame Refill

This block keeps a small set of 128-bit IPv6 addresses and answers membership lookups for a header-processing engine. The requester streams an address into the block one byte per cycle, most significant byte first. Each stored entry keeps a running match flag, and that flag drops as soon as one byte disagrees. When the last byte arrives, the block reports a hit with the lowest matching entry index, or it reports a miss.

On a miss the block does not replace a single line. It invalidates every entry and reloads the whole cache from the next frame of a backing routing-table memory, taken in round-robin order. It reads that frame one entry per granted bus cycle. During the refill the block holds `busy` and ignores new bytes. When the refill ends, it compares the missed address against the new contents in one pass and reports the final result. It does not start a second refill for the same lookup.

Top module: `addr_match_cache`

## Requirements
- R1: After reset every entry is invalid, the next frame to load is frame 0, and `busy`, `result_valid` and `tbl_rd_en` are low.
- R2: A lookup is 16 accepted bytes, and the first byte is address bits 127:120. When the address matches a valid entry, `result_valid` is high, `result_hit` is 1 and `result_index` gives the entry in the cycle after the 16th byte is accepted. No table read takes place.
- R3: An entry that differs from the lookup address in any single byte does not match. This holds for the first byte and for the last byte alike.
- R4: When several valid entries match, `result_index` is the lowest of them.
- R5: On a miss, `busy` is high in the cycle after the 16th byte and all entries are invalidated. The block then makes exactly 16 accepted reads, with `tbl_rd_addr` = {frame[1:0] in bits 5:4, entry[3:0] in bits 3:0}.
- R6: Each refill loads the frame after the one loaded last, modulo 4. The frame that just missed is therefore not reloaded.
- R7: A read counts as accepted only in a cycle where `tbl_rd_en` and `tbl_gnt` are both high. While the grant is low, the request and its address are held. The word on `tbl_rd_data` in the cycle after acceptance is written into the entry that was addressed.
- R8: After the refill, the saved address is compared once against the new contents. The block gives one result (a hit with its index, or a miss with index 0) in the cycle where `busy` falls, and starts no further refill.
- R9: Bytes presented while `busy` is high are ignored and do not disturb the next lookup.
- R10: `result_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| piece_valid | input | 1 | A lookup byte is presented |
| piece_data | input | 8 | Lookup byte, most significant first |
| busy | output | 1 | A refill or re-check is in progress; bytes are ignored |
| result_valid | output | 1 | Lookup result pulse |
| result_hit | output | 1 | Address found |
| result_index | output | 4 | Index of the matching entry, 0 on a miss |
| tbl_rd_en | output | 1 | Read request to the backing table |
| tbl_rd_addr | output | 6 | {frame, entry} read address |
| tbl_gnt | input | 1 | Bus granted to the read this cycle |
| tbl_rd_data | input | 128 | Table word, valid one cycle after an accepted read |

## Verification
The properties assume that the backing table answers exactly one cycle after each accepted read, and that the grant may fall in any cycle without breaking that rule. The bench models the table as a registered array that meets this timing. It drives the grant low every third cycle, so read requests are held across stalls. The properties assume nothing about the lookup stream. The stimulus therefore also pushes bytes in during refills, and it keeps every lookup to whole 16-byte groups.

// File: rtl/addr_match_cache.sv
module addr_match_cache #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 128,
  parameter int PIECE_W = 8,
  parameter int FRAMES  = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       piece_valid,
  input  logic [PIECE_W-1:0]                         piece_data,
  output logic                                       busy,
  output logic                                       result_valid,
  output logic                                       result_hit,
  output logic [$clog2(ENTRIES)-1:0]                 result_index,
  output logic                                       tbl_rd_en,
  output logic [$clog2(FRAMES)+$clog2(ENTRIES)-1:0]  tbl_rd_addr,
  input  logic                                       tbl_gnt,
  input  logic [ADDR_W-1:0]                          tbl_rd_data
);
  localparam int PIECES = ADDR_W / PIECE_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int FR_W   = $clog2(FRAMES);
  localparam int CNT_W  = $clog2(PIECES);
  localparam int TBL_AW = FR_W + IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_CHECK} state_t;

  state_t               state_q;
  logic [ADDR_W-1:0]    entry_q [ENTRIES];
  logic [ENTRIES-1:0]   valid_q, run_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [FR_W-1:0]      frame_q;
  logic [IDX_W:0]       issue_q;
  logic                 wr_pend_q;
  logic [IDX_W-1:0]     wr_idx_q;

  logic [ENTRIES-1:0]   byte_eq, full_eq, keep, final_vec;
  logic                 accept, last;

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    lowest = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) lowest = IDX_W'(i);
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [PIECE_W-1:0] pick;
    assign pick       = PIECE_W'(entry_q[g] >> (PIECE_W * (PIECES - 1 - int'(cnt_q))));
    assign byte_eq[g] = (pick == piece_data);
    assign full_eq[g] = (entry_q[g] == addr_q);
  end

  assign accept    = piece_valid && (state_q == S_IDLE);
  assign last      = accept && (cnt_q == CNT_W'(PIECES - 1));
  assign keep      = ((cnt_q == '0) ? valid_q : run_q) & byte_eq;
  assign final_vec = valid_q & full_eq;

  assign busy        = (state_q != S_IDLE);
  assign tbl_rd_en   = (state_q == S_FILL) && !issue_q[IDX_W];
  assign tbl_rd_addr = TBL_AW'({frame_q, issue_q[IDX_W-1:0]});

  always_ff @(posedge clk) begin
    if (wr_pend_q) entry_q[wr_idx_q] <= tbl_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      valid_q      <= '0;
      run_q        <= '0;
      cnt_q        <= '0;
      addr_q       <= '0;
      frame_q      <= FR_W'(FRAMES - 1);
      issue_q      <= '0;
      wr_pend_q    <= 1'b0;
      wr_idx_q     <= '0;
      result_valid <= 1'b0;
      result_hit   <= 1'b0;
      result_index <= '0;
    end else begin
      result_valid <= 1'b0;
      wr_pend_q    <= tbl_rd_en && tbl_gnt;
      wr_idx_q     <= issue_q[IDX_W-1:0];
      if (wr_pend_q) valid_q[wr_idx_q] <= 1'b1;
      case (state_q)
        S_IDLE: if (accept) begin
          cnt_q  <= last ? '0 : cnt_q + 1'b1;
          run_q  <= keep;
          addr_q <= {addr_q[ADDR_W-PIECE_W-1:0], piece_data};
          if (last) begin
            if (|keep) begin
              result_valid <= 1'b1;
              result_hit   <= 1'b1;
              result_index <= lowest(keep);
            end else begin
              state_q <= S_FILL;
              valid_q <= '0;
              issue_q <= '0;
              frame_q <= (frame_q == FR_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
            end
          end
        end
        S_FILL: begin
          if (tbl_rd_en && tbl_gnt) issue_q <= issue_q + 1'b1;
          if (issue_q[IDX_W] && !wr_pend_q) state_q <= S_CHECK;
        end
        S_CHECK: begin
          result_valid <= 1'b1;
          result_hit   <= |final_vec;
          result_index <= lowest(final_vec);
          state_q      <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

module addr_match_cache_chk #(
  parameter int IDX_W  = 4,
  parameter int TBL_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              result_valid,
  input logic              result_hit,
  input logic [IDX_W-1:0]  result_index,
  input logic              tbl_rd_en,
  input logic [TBL_AW-1:0] tbl_rd_addr,
  input logic              tbl_gnt
);
  assert_result_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> result_valid);
  assert_miss_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !result_hit) |-> (result_index == '0));
  assert_read_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> busy);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && !tbl_gnt) |=> (tbl_rd_en && $stable(tbl_rd_addr)));
  assert_frame_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && $past(tbl_rd_en)) |->
      (tbl_rd_addr[TBL_AW-1:IDX_W] == $past(tbl_rd_addr[TBL_AW-1:IDX_W])));
endmodule

bind addr_match_cache addr_match_cache_chk #(.IDX_W(IDX_W), .TBL_AW(TBL_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .result_valid(result_valid),
  .result_hit(result_hit), .result_index(result_index), .tbl_rd_en(tbl_rd_en),
  .tbl_rd_addr(tbl_rd_addr), .tbl_gnt(tbl_gnt)
);

// File: tb/addr_match_cache_tb.sv
`timescale 1ns/1ps
module addr_match_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         piece_valid = 1'b0;
  logic [7:0]   piece_data = '0;
  logic         busy, result_valid, result_hit, tbl_rd_en;
  logic [3:0]   result_index;
  logic [5:0]   tbl_rd_addr;
  logic         tbl_gnt = 1'b1;
  logic [127:0] tbl_rd_data = '0;

  int checks = 0, fails = 0, reads_seen = 0, frame_bad = 0;
  logic [1:0] mon_frame = '0;

  always #5 clk = ~clk;

  addr_match_cache dut_i (
    .clk(clk), .rst_n(rst_n), .piece_valid(piece_valid), .piece_data(piece_data),
    .busy(busy), .result_valid(result_valid), .result_hit(result_hit),
    .result_index(result_index), .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_gnt(tbl_gnt), .tbl_rd_data(tbl_rd_data)
  );

  // Table word for (frame, entry); frame 3 entry 13 duplicates entry 12 (R4)
  function automatic logic [127:0] word(input logic [1:0] f, input logic [3:0] i);
    logic [3:0] k;
    k = (f == 2'd3 && i == 4'd13) ? 4'd12 : i;
    return {16'h2001, 14'h0, f, 12'h0, k, 64'hDEAD_BEEF_0000_0000, 6'h0, f, 4'h0, k};
  endfunction

  always @(posedge clk)
    if (tbl_rd_en && tbl_gnt) tbl_rd_data <= word(tbl_rd_addr[5:4], tbl_rd_addr[3:0]);

  always @(posedge clk)
    if (rst_n && tbl_rd_en && tbl_gnt) begin
      reads_seen++;
      if (tbl_rd_addr[5:4] != mon_frame) frame_bad++;
    end

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      tbl_gnt = (k % 3) != 2;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic lookup(input logic [127:0] a, input bit eh, input logic [3:0] ei,
                        input bit er, input logic [1:0] ef, input bit inject);
    int r0, b0, w;
    mon_frame = ef;
    r0 = reads_seen;
    b0 = frame_bad;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      piece_valid = 1'b1;
      piece_data  = a[127 - 8*p -: 8];
    end
    @(negedge clk);
    piece_valid = 1'b0;
    if (!er) begin
      chk(result_valid && result_hit == eh && result_index == ei, "R2 hit result",
          {result_valid, result_hit, result_index}, {1'b1, eh, ei});
      chk(reads_seen == r0, "R2 no read on hit", reads_seen - r0, 0);
    end else begin
      chk(busy && !result_valid, "R5 busy after miss", {busy, result_valid}, 2'b10);
      if (inject) begin
        for (int j = 0; j < 5; j++) begin
          piece_valid = 1'b1;
          piece_data  = 8'h5A ^ 8'(j);
          @(negedge clk);
        end
        piece_valid = 1'b0;
      end
      w = 0;
      while (!result_valid && w < 300) begin
        @(negedge clk);
        w++;
      end
      chk(result_valid, "R8 result after refill", result_valid, 1);
      chk(result_hit == eh && result_index == ei, "R8 re-check result",
          {result_hit, result_index}, {eh, ei});
      chk(!busy, "R8 busy low with result", busy, 0);
      chk(reads_seen - r0 == 16, "R5 R7 accepted reads", reads_seen - r0, 16);
      chk(frame_bad == b0, "R6 frame read", frame_bad - b0, 0);
    end
    @(negedge clk);
    chk(!result_valid, "R10 single pulse", result_valid, 0);
  endtask

  // {frame, entry, exp_hit, exp_index, exp_refill, exp_frame}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 4'd5,  1'b1, 4'd5,  1'b1, 2'd0},  // R1 empty, R6 first frame 0
    {2'd0, 4'd0,  1'b1, 4'd0,  1'b0, 2'd0},  // R2
    {2'd0, 4'd15, 1'b1, 4'd15, 1'b0, 2'd0},  // R2
    {2'd1, 4'd3,  1'b1, 4'd3,  1'b1, 2'd1},  // R6
    {2'd0, 4'd2,  1'b0, 4'd0,  1'b1, 2'd2},  // R6 failed frame skipped, R8 miss
    {2'd3, 4'd12, 1'b1, 4'd12, 1'b1, 2'd3},  // R4 duplicate at 12 and 13
    {2'd3, 4'd13, 1'b1, 4'd12, 1'b0, 2'd3},  // R4
    {2'd0, 4'd9,  1'b1, 4'd9,  1'b1, 2'd0}   // R6 wrap
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !result_valid && !tbl_rd_en, "R1 in reset",
        {busy, result_valid, tbl_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !result_valid && !tbl_rd_en, "R1 after reset",
        {busy, result_valid, tbl_rd_en}, 0);

    for (int v = 0; v < 8; v++)
      lookup(word(VEC[v][13:12], VEC[v][11:8]), VEC[v][7], VEC[v][6:3],
             VEC[v][2], VEC[v][1:0], 1'b0);

    lookup(word(2'd0, 4'd4) ^ 128'h1, 1'b0, 4'd0, 1'b1, 2'd1, 1'b0);        // R3 last byte
    lookup(word(2'd1, 4'd6) ^ {1'b1, 127'h0}, 1'b0, 4'd0, 1'b1, 2'd2, 1'b0); // R3 first byte
    lookup(word(2'd3, 4'd1), 1'b1, 4'd1, 1'b1, 2'd3, 1'b1);                  // R9 bytes in refill
    lookup(word(2'd3, 4'd2), 1'b1, 4'd2, 1'b0, 2'd3, 1'b0);                  // R9 next lookup clean

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lookup(word(2'd3, 4'd2), 1'b0, 4'd0, 1'b1, 2'd0, 1'b0);                  // R1 R6 reset state
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    summary();
  end
endmodule